// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address by walking a page table that lives in ordinary memory. The top four address bits pick one of sixteen segment registers. The 24-bit virtual segment identifier in that register is mixed with the page index of the address to form a hash. The hash locates a group of eight two-word page table entries, and the walker reads the first word of each entry in turn over a single 32-bit request/acknowledge memory port.

When no entry in the first group matches, the walker searches the group at the complemented hash. On a hit it fetches the second word of the entry. It sets the referenced bit in that word, and also the changed bit when the access is a store, and writes the word back only if its value differs. It then reports the real address, the raw page protection field and the raw attribute byte of the selected segment register.

When translation is disabled for the kind of access requested, the walker returns the effective address unchanged and makes no memory access. Block translation and decoding of access rights are handled elsewhere.

Top module: `hpt_walker`

## Requirements
- R1: The segment register is chosen by effective-address bits 31:28. Its bits 23:0 are the virtual segment ID, and its bits 31:24 are returned unchanged on `seg_attr`.
- R2: The page index is address bits 27:12. The primary group address is `tbl_base + (((vsid ^ page_index) << 6) & tbl_mask)`. Entry k of a group holds its first word at offset 8k and its second word at offset 8k+4, and the entries are read in the order k = 0 to 7. Exactly one read is issued for each word examined.
- R3: An entry matches only if word-0 bit 31 (valid) is 1, word-0 bit 6 equals the current pass (0 for primary, 1 for secondary), bits 30:7 equal the virtual segment ID, and bits 5:0 equal page-index bits 15:10.
- R4: When all eight primary entries fail, the group at the bitwise complement of the 32-bit hash is searched. When that group also fails, `done` rises with `hit` = 0, `real_addr` = 0 and `prot_pp` = 0.
- R5: On a hit, the new second word is the old one with bit 8 (referenced) set, and with bit 7 (changed) also set for a store. It is written back to the same address only when it differs from the old value, and no other write occurs.
- R6: On a hit, `real_addr` is second-word bits 31:12 joined to effective-address bits 11:0.
- R7: On a walked hit, `wr_permit` is 1 only for a store (`req_acc` = 1). It is 0 for a load (0) or a fetch (2) and on every miss.
- R8: A fetch with `xlat_inst_en` = 0, or a load or store with `xlat_data_en` = 0, completes with no memory access. It returns `hit` = 1, `bypass` = 1, `wr_permit` = 1, `real_addr` equal to the effective address and `prot_pp` = 0. Otherwise `bypass` is 0.
- R9: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until the cycle `mem_ack` is seen. Each request transfers one 32-bit word.
- R10: `done` is high for exactly one cycle per accepted request, and the results stay valid until the next request. A `req_valid` that arrives while a walk is in progress is ignored. After reset `done` and `mem_req` are 0.
- R11: On a hit, `prot_pp` carries second-word bits 1:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation (accepted only when idle) |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| xlat_inst_en | input | 1 | Instruction translation enable |
| xlat_data_en | input | 1 | Data translation enable |
| seg_regs | input | 512 | Sixteen 32-bit segment registers, register n at bits 32n+31:32n |
| tbl_base | input | 32 | Byte address of the page table |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed (read data valid) |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation found (or bypassed) |
| bypass | output | 1 | Translation was disabled for this access |
| wr_permit | output | 1 | Write right granted |
| real_addr | output | 32 | Real address |
| prot_pp | output | 2 | Raw page protection field |
| seg_attr | output | 8 | Raw attribute byte of the selected segment register |

## Verification
The assertions watch, on every cycle, that a request stays stable until it is acknowledged and that `done` is a single-cycle pulse. They also check that a bypassed request never reaches memory, that any write carries the referenced bit and targets a second word, that the secondary pass starts only after the last primary entry, and that a granted write right belongs to a store or a bypass. Only the bench scenarios can show the rest. These are the hash and tag arithmetic, the order in which entries are scanned (seen through the exact number of reads), the shadowing of a secondary-flagged entry in the primary group, the suppression of write-back when the status bits are already set, and the way a later store revisits a page that an earlier load touched.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int WORD_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int SEG_SHIFT = 28;
  localparam int SEG_NUM   = 16;
  localparam int VSID_W    = 24;
  localparam int PIDX_W    = SEG_SHIFT - PAGE_BITS;
  localparam int API_W     = 6;
  localparam int TAG_SHIFT = API_W + 1;
  localparam int PTE_BYTES = 8;

  localparam logic [WORD_W-1:0] VALID_BIT = 32'h8000_0000;
  localparam logic [WORD_W-1:0] SEC_BIT   = 32'h1 << API_W;
  localparam logic [WORD_W-1:0] TAG_MASK  = ~(VALID_BIT | SEC_BIT);
  localparam logic [WORD_W-1:0] REF_BIT   = 32'h0000_0100;
  localparam logic [WORD_W-1:0] CHG_BIT   = 32'h0000_0080;
  localparam logic [WORD_W-1:0] OFS_MASK  = (32'h1 << PAGE_BITS) - 32'h1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TAG,
    ST_DATA,
    ST_WBACK,
    ST_DONE
  } walk_st_e;

  function automatic logic [PIDX_W-1:0] page_index(input logic [WORD_W-1:0] ea);
    return ea[SEG_SHIFT-1:PAGE_BITS];
  endfunction

  function automatic logic [WORD_W-1:0] group_hash(input logic [VSID_W-1:0] vsid,
                                                   input logic [PIDX_W-1:0] pidx,
                                                   input logic sec);
    logic [WORD_W-1:0] h;
    h = WORD_W'(vsid) ^ WORD_W'(pidx);
    return sec ? ~h : h;
  endfunction

  function automatic logic [WORD_W-1:0] group_base(input logic [WORD_W-1:0] base,
                                                   input logic [WORD_W-1:0] mask,
                                                   input logic [WORD_W-1:0] hash,
                                                   input int shift);
    return base + ((hash << shift) & mask);
  endfunction

  function automatic logic [WORD_W-1:0] compare_tag(input logic [VSID_W-1:0] vsid,
                                                    input logic [PIDX_W-1:0] pidx);
    return (WORD_W'(vsid) << TAG_SHIFT) | WORD_W'(pidx >> (PIDX_W - API_W));
  endfunction

  function automatic logic entry_hit(input logic [WORD_W-1:0] w0,
                                     input logic [WORD_W-1:0] tag,
                                     input logic sec);
    return ((w0 & VALID_BIT) != '0) && (w0[API_W] == sec) && ((w0 & TAG_MASK) == tag);
  endfunction

  function automatic logic [WORD_W-1:0] status_update(input logic [WORD_W-1:0] w1,
                                                      input logic store);
    return w1 | REF_BIT | (store ? CHG_BIT : '0);
  endfunction

  function automatic logic [WORD_W-1:0] real_address(input logic [WORD_W-1:0] w1,
                                                     input logic [WORD_W-1:0] ea);
    return (w1 & ~OFS_MASK) | (ea & OFS_MASK);
  endfunction
endpackage

// File: rtl/hpt_seg_select.sv
module hpt_seg_select
  import hpt_pkg::*;
(
  input  logic [SEG_NUM*WORD_W-1:0] seg_flat,
  input  logic [WORD_W-1:0]         ea,
  output logic [WORD_W-1:0]         seg_word
);
  localparam int SEL_W = $clog2(SEG_NUM);

  logic [WORD_W-1:0] seg_arr [SEG_NUM];

  for (genvar g = 0; g < SEG_NUM; g++) begin : g_unpack
    assign seg_arr[g] = seg_flat[g*WORD_W +: WORD_W];
  end

  assign seg_word = seg_arr[ea[WORD_W-1 -: SEL_W]];
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8,
  localparam int IDX_W = $clog2(GROUP_ENTRIES)
)(
  input  logic [VSID_W-1:0] vsid,
  input  logic [WORD_W-1:0] ea,
  input  logic              sec,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] tag_addr,
  output logic [WORD_W-1:0] data_addr,
  output logic [WORD_W-1:0] cmp_tag
);
  localparam int GROUP_BYTES = GROUP_ENTRIES * PTE_BYTES;
  localparam int GRP_SHIFT   = $clog2(GROUP_BYTES);
  localparam int ENT_SHIFT   = $clog2(PTE_BYTES);

  logic [PIDX_W-1:0] pidx;
  logic [WORD_W-1:0] grp_addr;

  always_comb begin
    pidx      = page_index(ea);
    grp_addr  = group_base(base, mask, group_hash(vsid, pidx, sec), GRP_SHIFT);
    tag_addr  = grp_addr + (WORD_W'(idx) << ENT_SHIFT);
    data_addr = tag_addr + WORD_W'(WORD_W / 8);
    cmp_tag   = compare_tag(vsid, pidx);
  end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] cmp_tag,
  input  logic              sec,
  input  logic              store,
  input  logic [WORD_W-1:0] ea,
  output logic              tag_match,
  output logic [WORD_W-1:0] upd_word,
  output logic              upd_needed,
  output logic [WORD_W-1:0] real_out
);
  always_comb begin
    tag_match  = entry_hit(word, cmp_tag, sec);
    upd_word   = status_update(word, store);
    upd_needed = (upd_word != word);
    real_out   = real_address(word, ea);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [31:0]               req_ea,
  input  logic [1:0]                req_acc,
  input  logic                      xlat_inst_en,
  input  logic                      xlat_data_en,
  input  logic [SEG_NUM*WORD_W-1:0] seg_regs,
  input  logic [31:0]               tbl_base,
  input  logic [31:0]               tbl_mask,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [31:0]               mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_ack,
  input  logic [31:0]               mem_rdata,
  output logic                      done,
  output logic                      hit,
  output logic                      bypass,
  output logic                      wr_permit,
  output logic [31:0]               real_addr,
  output logic [1:0]                prot_pp,
  output logic [7:0]                seg_attr
);
  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_st_e          state;
  logic [WORD_W-1:0] ea_q;
  logic [WORD_W-1:0] seg_q;
  logic              store_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] wb_word_q;
  logic              hit_q, byp_q, wrp_q;
  logic [WORD_W-1:0] real_q;
  logic [1:0]        pp_q;

  // named internal events
  logic              accept;
  logic              is_fetch;
  logic              bypass_req;
  logic [WORD_W-1:0] seg_now;
  logic [WORD_W-1:0] tag_addr, data_addr, cmp_tag;
  logic              tag_match, upd_needed;
  logic [WORD_W-1:0] upd_word, real_calc;
  logic              tag_ack, data_ack, wb_ack;
  logic              group_exhausted;

  hpt_seg_select u_seg (
    .seg_flat (seg_regs),
    .ea       (req_ea),
    .seg_word (seg_now)
  );

  hpt_addr_gen #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_addr (
    .vsid      (seg_q[VSID_W-1:0]),
    .ea        (ea_q),
    .sec       (pass_q),
    .idx       (idx_q),
    .base      (tbl_base),
    .mask      (tbl_mask),
    .tag_addr  (tag_addr),
    .data_addr (data_addr),
    .cmp_tag   (cmp_tag)
  );

  hpt_entry_eval u_eval (
    .word       (mem_rdata),
    .cmp_tag    (cmp_tag),
    .sec        (pass_q),
    .store      (store_q),
    .ea         (ea_q),
    .tag_match  (tag_match),
    .upd_word   (upd_word),
    .upd_needed (upd_needed),
    .real_out   (real_calc)
  );

  assign accept          = (state == ST_IDLE) && req_valid;
  assign is_fetch        = (req_acc == ACC_FETCH);
  assign bypass_req      = is_fetch ? !xlat_inst_en : !xlat_data_en;
  assign tag_ack         = (state == ST_TAG) && mem_ack;
  assign data_ack        = (state == ST_DATA) && mem_ack;
  assign wb_ack          = (state == ST_WBACK) && mem_ack;
  assign group_exhausted = tag_ack && !tag_match && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ea_q      <= '0;
      seg_q     <= '0;
      store_q   <= 1'b0;
      pass_q    <= 1'b0;
      idx_q     <= '0;
      wb_word_q <= '0;
      hit_q     <= 1'b0;
      byp_q     <= 1'b0;
      wrp_q     <= 1'b0;
      real_q    <= '0;
      pp_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ea_q    <= req_ea;
            seg_q   <= seg_now;
            store_q <= (req_acc == ACC_STORE);
            pass_q  <= 1'b0;
            idx_q   <= '0;
            pp_q    <= '0;
            if (bypass_req) begin
              hit_q  <= 1'b1;
              byp_q  <= 1'b1;
              wrp_q  <= 1'b1;
              real_q <= req_ea;
              state  <= ST_DONE;
            end else begin
              hit_q  <= 1'b0;
              byp_q  <= 1'b0;
              wrp_q  <= 1'b0;
              real_q <= '0;
              state  <= ST_TAG;
            end
          end
        end
        ST_TAG: begin
          if (tag_ack) begin
            if (tag_match) begin
              state <= ST_DATA;
            end else if (group_exhausted) begin
              idx_q <= '0;
              if (!pass_q) begin
                pass_q <= 1'b1;
              end else begin
                state <= ST_DONE;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (data_ack) begin
            wb_word_q <= upd_word;
            hit_q     <= 1'b1;
            wrp_q     <= store_q;
            real_q    <= real_calc;
            pp_q      <= mem_rdata[1:0];
            state     <= upd_needed ? ST_WBACK : ST_DONE;
          end
        end
        ST_WBACK: begin
          if (wb_ack) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == ST_TAG) || (state == ST_DATA) || (state == ST_WBACK);
    mem_we    = (state == ST_WBACK);
    mem_wdata = (state == ST_WBACK) ? wb_word_q : '0;
    mem_addr  = (state == ST_TAG) ? tag_addr : data_addr;
  end

  assign done      = (state == ST_DONE);
  assign hit       = hit_q;
  assign bypass    = byp_q;
  assign wr_permit = wrp_q;
  assign real_addr = real_q;
  assign prot_pp   = pp_q;
  assign seg_attr  = seg_q[WORD_W-1 -: 8];

  // R9: an outstanding request is held unchanged until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a request taken with translation off never touches memory
  assert_bypass_nomem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bypass_req) |=> (!mem_req && done));

  // R5: every write sets the referenced bit and lands on a second word
  assert_wb_refbit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[8] && mem_addr[2]));

  // R4: the secondary pass begins only after the final primary entry
  assert_secondary_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_q) |-> ($past(idx_q) == LAST_IDX && $past(state) == ST_TAG));

  // R7: write right only for stores or untranslated accesses
  assert_write_right_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_permit) |-> (bypass || store_q));

  // R6: the page offset always passes straight through on a hit
  assert_offset_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hit) |-> (real_addr[11:0] == ea_q[11:0]));
endmodule

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
module tb_hpt_walker;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam logic [31:0] MASK = 32'h0000_1FC0;
  localparam int MEM_WORDS = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_acc = '0;
  logic        xlat_inst_en = 1'b1, xlat_data_en = 1'b1;
  logic [511:0] seg_regs;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, hit, bypass, wr_permit;
  logic [31:0] real_addr;
  logic [1:0]  prot_pp;
  logic [7:0]  seg_attr;

  logic [31:0] segs [16];
  logic [31:0] mem [MEM_WORDS];

  always_comb for (int i = 0; i < 16; i++) seg_regs[i*32 +: 32] = segs[i];

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea), .req_acc(req_acc),
    .xlat_inst_en(xlat_inst_en), .xlat_data_en(xlat_data_en), .seg_regs(seg_regs),
    .tbl_base(BASE), .tbl_mask(MASK), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .hit(hit), .bypass(bypass), .wr_permit(wr_permit),
    .real_addr(real_addr), .prot_pp(prot_pp), .seg_attr(seg_attr)
  );

  int n_checks = 0;
  int n_errs = 0;

  function automatic int midx(input logic [31:0] a);
    logic [31:0] d;
    d = (a - BASE) >> 2;
    return int'(d[10:0]);
  endfunction

  // memory responder: random latency, records reads and the last write
  int unsigned rd_cnt = 0, wr_cnt = 0, gap = 0;
  logic [31:0] wr_addr_l = '0, wr_data_l = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      if (gap == 0) begin
        mem_ack <= 1'b1;
        gap     <= $urandom % 3;
        if (mem_we) begin
          wr_cnt    <= wr_cnt + 1;
          wr_addr_l <= mem_addr;
          wr_data_l <= mem_wdata;
          mem_rdata <= '0;
        end else begin
          rd_cnt    <= rd_cnt + 1;
          mem_rdata <= mem[midx(mem_addr)];
        end
      end else begin
        gap <= gap - 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // expectation model
  logic        e_hit, e_byp, e_wrp, e_write;
  logic [31:0] e_real, e_waddr, e_wdata;
  logic [1:0]  e_pp;
  int          e_reads;

  task automatic predict(input logic [31:0] ea, input logic [1:0] acc, input logic ir, input logic dr);
    logic [31:0] sr, h, g, w0, w1, nw, daddr;
    logic [23:0] vsid;
    logic [15:0] pg;
    bit found, fetch, store;
    sr = segs[ea[31:28]];
    vsid = sr[23:0];
    pg = ea[27:12];
    fetch = (acc == 2'd2);
    store = (acc == 2'd1);
    e_reads = 0; e_write = 0; e_waddr = '0; e_wdata = '0;
    e_hit = 0; e_byp = 0; e_wrp = 0; e_real = '0; e_pp = '0;
    if ((fetch && !ir) || (!fetch && !dr)) begin
      e_hit = 1; e_byp = 1; e_wrp = 1; e_real = ea;
      return;
    end
    found = 0;
    daddr = '0;
    for (int p = 0; p < 2; p++) begin
      if (!found) begin
        h = {8'h00, vsid} ^ {16'h0000, pg};
        if (p == 1) h = ~h;
        g = BASE + ((h << 6) & MASK);
        for (int k = 0; k < 8; k++) begin
          if (!found) begin
            w0 = mem[midx(g + 32'(k) * 8)];
            e_reads++;
            if (w0[31] && (w0[6] == p[0]) && (w0[30:7] == vsid) && (w0[5:0] == pg[15:10])) begin
              found = 1;
              daddr = g + 32'(k) * 8 + 4;
            end
          end
        end
      end
    end
    if (found) begin
      w1 = mem[midx(daddr)];
      e_reads++;
      nw = w1 | 32'h100 | (store ? 32'h80 : 32'h0);
      e_write = (nw != w1);
      e_waddr = daddr;
      e_wdata = nw;
      e_hit = 1;
      e_real = {w1[31:12], ea[11:0]};
      e_pp = w1[1:0];
      e_wrp = store;
    end
  endtask

  task automatic plant(input logic [31:0] ea, input bit p, input int slot, input logic [31:0] w1,
                       input bit valid, input bit hflip);
    logic [31:0] h, g;
    logic [23:0] vsid;
    logic [15:0] pg;
    vsid = segs[ea[31:28]][23:0];
    pg = ea[27:12];
    h = {8'h00, vsid} ^ {16'h0000, pg};
    if (p) h = ~h;
    g = BASE + ((h << 6) & MASK) + 32'(slot) * 8;
    mem[midx(g)]     = {valid, vsid, p ^ hflip, pg[15:10]};
    mem[midx(g + 4)] = w1;
  endtask

  task automatic run_req(input logic [31:0] ea, input logic [1:0] acc, input logic ir, input logic dr,
                         input string scen, input bit poke);
    int unsigned r0, w0c;
    int n;
    predict(ea, acc, ir, dr);
    r0 = rd_cnt;
    w0c = wr_cnt;
    @(negedge clk);
    req_ea = ea; req_acc = acc; xlat_inst_en = ir; xlat_data_en = dr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke && !done) begin
      @(negedge clk);
      req_ea = ~ea; req_acc = 2'd1; xlat_data_en = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      xlat_data_en = dr;
    end
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, {scen, " R10 done seen"}, 32'(done), 32'h1);
    check(hit == e_hit, {scen, " R4 hit"}, 32'(hit), 32'(e_hit));
    check(real_addr == e_real, {scen, " R6 real_addr"}, real_addr, e_real);
    check(prot_pp == e_pp, {scen, " R11 prot_pp"}, 32'(prot_pp), 32'(e_pp));
    check(seg_attr == segs[ea[31:28]][31:24], {scen, " R1 seg_attr"}, 32'(seg_attr), 32'(segs[ea[31:28]][31:24]));
    check(wr_permit == e_wrp, {scen, " R7 wr_permit"}, 32'(wr_permit), 32'(e_wrp));
    check(bypass == e_byp, {scen, " R8 bypass"}, 32'(bypass), 32'(e_byp));
    check((rd_cnt - r0) == e_reads, {scen, " R2 R9 read count"}, rd_cnt - r0, 32'(e_reads));
    check((wr_cnt - w0c) == 32'(e_write), {scen, " R5 write count"}, wr_cnt - w0c, 32'(e_write));
    if (e_write && wr_cnt != w0c) begin
      check(wr_addr_l == e_waddr && wr_data_l == e_wdata, {scen, " R5 write data"}, wr_data_l, e_wdata);
      mem[midx(wr_addr_l)] = wr_data_l;
    end
    @(negedge clk);
    if (poke) begin
      n = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (done) n++;
      end
      check(n == 0, {scen, " R10 busy request ignored"}, 32'(n), 32'h0);
    end
  endtask

  logic [31:0] ea, prev_ea;
  logic [1:0]  acc, prev_acc;

  initial begin
    void'($urandom(32'h0000_5EED));
    for (int i = 0; i < 16; i++) segs[i] = {$urandom % 16, 4'h0, 24'($urandom)};
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = $urandom & 32'h7FFF_FFFF;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && mem_req == 1'b0, "reset R10 idle outputs", {30'h0, done, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: untranslated fetch and load
    run_req(32'h1234_5678, 2'd2, 1'b0, 1'b1, "R8 fetch bypass", 0);
    run_req(32'hA000_0FFC, 2'd0, 1'b1, 1'b0, "R8 load bypass", 0);
    // R8: fetch still walks when only data translation is off
    plant(32'h3001_2345, 0, 0, 32'h0ABC_D002, 1, 0);
    run_req(32'h3001_2345, 2'd2, 1'b1, 1'b0, "R8 fetch walks", 0);
    // R2: last slot of primary group, load sets referenced only
    plant(32'h5FFF_F010, 0, 7, 32'h7777_7001, 1, 0);
    run_req(32'h5FFF_F010, 2'd0, 1'b1, 1'b1, "R2 slot7 load", 0);
    // R4: secondary group hit on a store
    plant(32'h7003_4ABC, 1, 3, 32'h1111_1003, 1, 0);
    run_req(32'h7003_4ABC, 2'd1, 1'b1, 1'b1, "R4 secondary store", 0);
    // R3: secondary-flagged entry in primary group must not match
    plant(32'h9055_5000, 0, 2, 32'h2222_2000, 1, 1);
    run_req(32'h9055_5000, 2'd0, 1'b1, 1'b1, "R3 wrong pass flag", 0);
    // R3: invalid entry must not match
    plant(32'hB066_6000, 0, 1, 32'h3333_3000, 0, 0);
    run_req(32'hB066_6000, 2'd0, 1'b1, 1'b1, "R3 invalid entry", 0);
    // R5: store on entry with both bits set issues no write
    plant(32'hC077_7123, 0, 4, 32'h4444_4181, 1, 0);
    run_req(32'hC077_7123, 2'd1, 1'b1, 1'b1, "R5 no write store", 0);
    // R5 R7: load then store on same page
    plant(32'hD088_8456, 0, 5, 32'h5555_5002, 1, 0);
    run_req(32'hD088_8456, 2'd0, 1'b1, 1'b1, "R7 load first", 0);
    run_req(32'hD088_8456, 2'd0, 1'b1, 1'b1, "R5 load again", 0);
    run_req(32'hD088_8456, 2'd1, 1'b1, 1'b1, "R7 store later", 0);
    // R10: request during a walk is ignored
    plant(32'hE099_9000, 1, 6, 32'h6666_6003, 1, 0);
    run_req(32'hE099_9000, 2'd0, 1'b1, 1'b1, "R10 busy poke", 1);

    prev_ea = 32'h0; prev_acc = 2'd0;
    for (int t = 0; t < 300; t++) begin
      if (t > 0 && ($urandom % 5) == 0) begin
        ea = prev_ea;
        acc = ($urandom % 2 == 0) ? 2'd1 : prev_acc;
      end else begin
        ea = $urandom;
        acc = 2'($urandom % 3);
        if (($urandom % 10) < 6)
          plant(ea, 1'($urandom), int'($urandom % 8), $urandom, 1, 0);
      end
      run_req(ea, acc, ($urandom % 10) != 0, ($urandom % 10) != 0, "random", 0);
      prev_ea = ea; prev_acc = acc;
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule